// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block watches every cycle on a shared address/data bus and raises a break request when a cycle meets the conditions programmed into either of two independent channels. Each channel has its own target address, an enable, a selector for the cycle kind (instruction fetch, data access or both) and a selector for the direction (read, write or both). The second channel can also compare bus data against a target value, under a per-bit mask.

The address compare depends on the width of the access. A longword cycle ignores the two lowest address bits and a word cycle ignores the lowest bit. A byte cycle compares every bit. A programmed byte address therefore hits any wider access that covers that byte. The data condition applies only to data cycles, so a fetch break on the second channel ignores the data registers.

A channel that hits latches its flag on the clock edge that ends the valid bus cycle. The flag holds until a one-cycle clear pulse. The break request is the OR of both flags. Cycles from any bus master are compared in the same way.

Top module: `bbc_top`

## Requirements
- R1: A byte cycle (size code 00) matches only when all 32 address bits equal the channel address.
- R2: A word cycle (size code 01) compares address bits 31..1 and ignores bit 0.
- R3: A longword cycle (size code 10) compares address bits 31..2 and ignores bits 1..0.
- R4: A cycle with the reserved size code 11 never matches on either channel.
- R5: Kind select bit 0 allows fetch cycles (fetch input 1) and bit 1 allows data cycles (fetch input 0). Code 00 matches nothing and code 11 matches both kinds.
- R6: Direction select bit 0 allows reads (write input 0) and bit 1 allows writes (write input 1). Code 00 matches nothing and code 11 matches both directions.
- R7: On a data cycle, channel B matches only when every bus data bit whose mask bit is 0 equals the channel B data value. Bus data bits whose mask bit is 1 are ignored.
- R8: On a fetch cycle, channel B ignores the bus data and the data/mask values.
- R9: A channel whose enable is 0 never sets its flag.
- R10: A flag rises on the clock edge that samples a valid matching cycle. It stays set until its clear input is high at an edge. If a hit and a clear fall on the same edge, the hit wins.
- R11: The break request is high exactly when at least one channel flag is high.
- R12: After reset both flags and the break request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_size | input | 2 | 00 byte, 01 word, 10 longword, 11 reserved |
| bus_write | input | 1 | 1 write, 0 read |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data access |
| a_en | input | 1 | Channel A enable |
| a_addr | input | 32 | Channel A target address |
| a_kind_sel | input | 2 | Channel A kind select (bit0 fetch, bit1 data) |
| a_dir_sel | input | 2 | Channel A direction select (bit0 read, bit1 write) |
| a_clr | input | 1 | Clear pulse for channel A flag |
| b_en | input | 1 | Channel B enable |
| b_addr | input | 32 | Channel B target address |
| b_kind_sel | input | 2 | Channel B kind select |
| b_dir_sel | input | 2 | Channel B direction select |
| b_data | input | 32 | Channel B target data |
| b_dmask | input | 32 | Channel B data mask, 1 excludes the bit |
| b_clr | input | 1 | Clear pulse for channel B flag |
| a_hit | output | 1 | Channel A sticky match flag |
| b_hit | output | 1 | Channel B sticky match flag |
| brk_req | output | 1 | Combined break request |

## Verification
Every decision in this block becomes visible at the flag outputs one edge after the deciding cycle. A wrong size mask, a swapped select bit or a data compare leaking into fetch cycles shows up as a flag that is wrong on the very next sample. A broken hold or clear path in a flag register shows up as a flag that drops or stays set during idle cycles, within one clock of the clear pulse or of the first non-matching cycle. The sweep covers every combination of low address bits, size, kind, direction and cycle type, so each such fault reaches the ports within a single cycle of the pattern that exposes it.

// File: rtl/bbc_pkg.sv
// Package for the bus break comparator.
// Holds the access size encoding and the select decoding helper.
// Assumes two-bit select fields: bit 0 gates the "first" case, bit 1 the other.
package bbc_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // Returns 1 when the select field allows the observed case.
    function automatic logic sel_allows(input logic [1:0] sel, input logic second_case);
        return second_case ? sel[1] : sel[0];
    endfunction

endpackage

// File: rtl/bbc_addr_cmp.sv
// Size-aware address comparator.
// Drops the address bits below the access width before comparing, so a
// narrow programmed address hits any wider access that covers it.
// Assumes ADDR_W >= 2. The reserved size code never matches.
module bbc_addr_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        size,
    output logic              hit
);
    import bbc_pkg::*;

    localparam int LOW_W = 2;

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] diff;
    logic              size_ok;

    // Build the mask of address bits that take part for this access size.
    always_comb begin
        keep_mask = '1;
        size_ok   = 1'b1;
        unique case (size_e'(size))
            SZ_BYTE: keep_mask = '1;
            SZ_WORD: keep_mask[0] = 1'b0;
            SZ_LONG: keep_mask[LOW_W-1:0] = '0;
            default: size_ok = 1'b0;
        endcase
    end

    // Compare only the kept bits.
    always_comb begin
        diff = (bus_addr ^ cfg_addr) & keep_mask;
        hit  = size_ok && (diff == '0);
    end

endmodule

// File: rtl/bbc_cond_chk.sv
// Cycle kind and direction filter.
// Checks that the select fields allow the current cycle's kind (fetch/data)
// and direction (read/write). Code 00 in either field blocks every cycle.
module bbc_cond_chk (
    input  logic [1:0] kind_sel,
    input  logic [1:0] dir_sel,
    input  logic       is_fetch,
    input  logic       is_write,
    output logic       ok
);
    import bbc_pkg::*;

    logic kind_ok;
    logic dir_ok;

    // Kind: bit 0 fetch, bit 1 data. Direction: bit 0 read, bit 1 write.
    always_comb begin
        kind_ok = sel_allows(kind_sel, !is_fetch);
        dir_ok  = sel_allows(dir_sel, is_write);
        ok      = kind_ok && dir_ok;
    end

endmodule

// File: rtl/bbc_data_cmp.sv
// Masked data comparator.
// Compares bus data to a target on data cycles. A mask bit of 1 excludes
// that bit. Fetch cycles always pass, because the data condition does not
// apply to them.
module bbc_data_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic              is_fetch,
    output logic              ok
);
    logic [DATA_W-1:0] diff;

    // Reduce the masked difference; bypass it on fetch cycles.
    always_comb begin
        diff = (bus_data ^ cfg_data) & ~cfg_mask;
        ok   = is_fetch || (diff == '0);
    end

endmodule

// File: rtl/bbc_channel.sv
// One break channel: address, condition and optional data compare,
// plus the sticky match flag.
// HAS_DATA selects whether the masked data compare is built.
// The flag sets on a valid hit and clears on a clear pulse; a hit wins
// over a clear on the same edge.
module bbc_channel #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter bit HAS_DATA = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_fetch,
    input  logic              en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [1:0]        kind_sel,
    input  logic [1:0]        dir_sel,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic              clr,
    output logic              flag
);
    logic addr_ok;
    logic cond_ok;
    logic data_ok;
    logic hit_now;

    bbc_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
        .bus_addr (bus_addr),
        .cfg_addr (cfg_addr),
        .size     (bus_size),
        .hit      (addr_ok)
    );

    bbc_cond_chk u_cond (
        .kind_sel (kind_sel),
        .dir_sel  (dir_sel),
        .is_fetch (bus_fetch),
        .is_write (bus_write),
        .ok       (cond_ok)
    );

    generate
        if (HAS_DATA) begin : g_data
            bbc_data_cmp #(.DATA_W(DATA_W)) u_data (
                .bus_data (bus_data),
                .cfg_data (cfg_data),
                .cfg_mask (cfg_mask),
                .is_fetch (bus_fetch),
                .ok       (data_ok)
            );
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, cfg_data, cfg_mask};
            assign data_ok     = 1'b1;
        end
    endgenerate

    // Combine every enabled condition for this cycle.
    always_comb begin
        hit_now = bus_valid && en && addr_ok && cond_ok && data_ok;
    end

    // Sticky flag: set on hit, cleared by pulse, hit has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit_now) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/bbc_top.sv
// Bus break comparator top.
// Two channels watch the same bus. Channel A compares address and cycle
// attributes only. Channel B also compares masked data on data cycles.
// The break request is the OR of the two sticky flags. Configuration
// inputs are expected to be stable while cycles are being compared.
module bbc_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        bus_size,
    input  logic              bus_write,
    input  logic              bus_fetch,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [1:0]        a_kind_sel,
    input  logic [1:0]        a_dir_sel,
    input  logic              a_clr,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [1:0]        b_kind_sel,
    input  logic [1:0]        b_dir_sel,
    input  logic [DATA_W-1:0] b_data,
    input  logic [DATA_W-1:0] b_dmask,
    input  logic              b_clr,
    output logic              a_hit,
    output logic              b_hit,
    output logic              brk_req
);
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0] flags;

    bbc_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(1'b0)) u_ch_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_size  (bus_size),
        .bus_write (bus_write),
        .bus_fetch (bus_fetch),
        .en        (a_en),
        .cfg_addr  (a_addr),
        .kind_sel  (a_kind_sel),
        .dir_sel   (a_dir_sel),
        .cfg_data  ('0),
        .cfg_mask  ('1),
        .clr       (a_clr),
        .flag      (flags[0])
    );

    bbc_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(1'b1)) u_ch_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_size  (bus_size),
        .bus_write (bus_write),
        .bus_fetch (bus_fetch),
        .en        (b_en),
        .cfg_addr  (b_addr),
        .kind_sel  (b_kind_sel),
        .dir_sel   (b_dir_sel),
        .cfg_data  (b_data),
        .cfg_mask  (b_dmask),
        .clr       (b_clr),
        .flag      (flags[1])
    );

    // Drive the outputs from the channel flags.
    always_comb begin
        a_hit   = flags[0];
        b_hit   = flags[1];
        brk_req = |flags;
    end

endmodule

// File: rtl/bbc_chk.sv
// Property checker for bbc_top, attached by bind.
// Assumes the synchronous active-low reset of the top.
module bbc_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_write,
    input logic              bus_fetch,
    input logic              a_en,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_clr,
    input logic              a_hit,
    input logic              b_en,
    input logic [ADDR_W-1:0] b_addr,
    input logic [1:0]        b_kind_sel,
    input logic [1:0]        b_dir_sel,
    input logic              b_hit,
    input logic              brk_req
);
    // R9
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_hit) |-> $past(a_en && bus_valid));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_hit && !a_clr |=> a_hit);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_clr && !bus_valid |=> !a_hit);

    // R4
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_size == 2'b11 && !a_hit |=> !a_hit);

    // R1
    byte_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_size == 2'b00 && bus_addr != a_addr && !a_hit |=> !a_hit);

    // R8
    fetch_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && b_en && bus_fetch && b_kind_sel[0] && bus_size == 2'b00 &&
        bus_addr == b_addr && (bus_write ? b_dir_sel[1] : b_dir_sel[0]) |=> b_hit);

    // R11
    brk_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_req) |-> $past(bus_valid));

endmodule

bind bbc_top bbc_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_bbc_top.sv
`timescale 1ns/1ps
module sim_bbc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_write = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        a_en = 1'b0;
    logic [31:0] a_addr = '0;
    logic [1:0]  a_kind_sel = '0;
    logic [1:0]  a_dir_sel = '0;
    logic        a_clr = 1'b0;
    logic        b_en = 1'b0;
    logic [31:0] b_addr = '0;
    logic [1:0]  b_kind_sel = '0;
    logic [1:0]  b_dir_sel = '0;
    logic [31:0] b_data = '0;
    logic [31:0] b_dmask = '0;
    logic        b_clr = 1'b0;
    logic        a_hit;
    logic        b_hit;
    logic        brk_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bbc_top u0 (.*);

    function automatic bit exp_addr(input logic [31:0] c, input logic [31:0] b, input logic [1:0] s);
        case (s)
            2'b00: return c == b;
            2'b01: return (c >> 1) == (b >> 1);
            2'b10: return (c >> 2) == (b >> 2);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit exp_sel(input logic [1:0] sel, input bit second);
        return (sel == 2'b11) || (sel == 2'b01 && !second) || (sel == 2'b10 && second);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Present one valid cycle; flags are sampled on the next falling edge.
    task automatic bus_cycle(input logic [31:0] ad, input logic [31:0] da, input logic [1:0] sz,
                             input logic wr, input logic fe);
        @(negedge clk);
        bus_addr = ad; bus_data = da; bus_size = sz; bus_write = wr; bus_fetch = fe;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic clear_both();
        a_clr = 1'b1; b_clr = 1'b1;
        @(negedge clk);
        a_clr = 1'b0; b_clr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string rq;
        bit ea;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 a_hit", a_hit, 1'b0);
        check("R12 b_hit", b_hit, 1'b0);
        check("R12 brk_req", brk_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: channel A enabled, channel B same setup but disabled (R9)
        a_en = 1'b1; b_en = 1'b0; b_dmask = '1;
        for (int ca = 0; ca < 4; ca++) begin
            for (int ba = 0; ba < 4; ba++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int ks = 0; ks < 4; ks++) begin
                        for (int ds = 0; ds < 4; ds++) begin
                            for (int fw = 0; fw < 4; fw++) begin
                                a_addr = 32'h0000_1000 | ca; b_addr = a_addr;
                                a_kind_sel = 2'(ks); a_dir_sel = 2'(ds);
                                b_kind_sel = 2'(ks); b_dir_sel = 2'(ds);
                                bus_cycle(32'h0000_1000 | ba, 32'h0, 2'(sz), fw[0], fw[1]);
                                ea = exp_addr(a_addr, 32'h0000_1000 | ba, 2'(sz)) &&
                                     exp_sel(2'(ks), !fw[1]) && exp_sel(2'(ds), fw[0]);
                                rq = (sz == 0) ? "R1 R5 R6" : (sz == 1) ? "R2 R5 R6" :
                                     (sz == 2) ? "R3 R5 R6" : "R4";
                                check(rq, a_hit, ea);
                                check("R9 disabled B", b_hit, 1'b0);
                                check("R11 brk", brk_req, ea);
                                clear_both();
                            end
                        end
                    end
                end
            end
        end

        // Upper address bit mismatches never hit (R1 R2 R3)
        a_kind_sel = 2'b11; a_dir_sel = 2'b11; a_addr = 32'h0000_1003;
        for (int bit_i = 2; bit_i < 32; bit_i += 3) begin
            for (int sz = 0; sz < 3; sz++) begin
                bus_cycle(a_addr ^ (32'h1 << bit_i), 32'h0, 2'(sz), 1'b0, 1'b0);
                check("R1 R2 R3 upper bits", a_hit, 1'b0);
                clear_both();
            end
        end
        // Covering accesses for a byte address (R2 R3)
        bus_cycle(32'h0000_1000, 32'h0, 2'b10, 1'b0, 1'b0);
        check("R3 long covers byte", a_hit, 1'b1);
        clear_both();
        bus_cycle(32'h0000_1002, 32'h0, 2'b01, 1'b1, 1'b0);
        check("R2 word covers byte", a_hit, 1'b1);
        clear_both();

        // Channel B data compare (R7) and fetch bypass (R8)
        a_en = 1'b0;
        b_en = 1'b1; b_addr = 32'h0000_2001; b_kind_sel = 2'b11; b_dir_sel = 2'b11;
        b_data = 32'h5A3C_0F96;
        for (int m = 0; m < 3; m++) begin
            b_dmask = (m == 0) ? 32'h0 : (m == 1) ? 32'hFFFF_0000 : 32'h0F0F_0F0F;
            for (int fe = 0; fe < 2; fe++) begin
                bus_cycle(b_addr, b_data, 2'b00, 1'b0, fe[0]);
                check("R7 exact data", b_hit, 1'b1);
                clear_both();
                for (int i = 0; i < 32; i++) begin
                    bus_cycle(b_addr, b_data ^ (32'h1 << i), 2'b00, 1'b1, fe[0]);
                    check(fe ? "R8 fetch ignores data" : "R7 masked data",
                          b_hit, fe ? 1'b1 : b_dmask[i]);
                    check("R9 disabled A", a_hit, 1'b0);
                    clear_both();
                end
            end
        end

        // Sticky flag, clear, and hit-over-clear (R10 R11)
        b_dmask = '1;
        bus_cycle(b_addr, 32'h0, 2'b00, 1'b0, 1'b0);
        check("R10 set", b_hit, 1'b1);
        repeat (3) bus_cycle(32'h0000_3000, 32'h0, 2'b00, 1'b0, 1'b0);
        check("R10 sticky", b_hit, 1'b1);
        check("R11 brk from B", brk_req, 1'b1);
        clear_both();
        check("R10 cleared", b_hit, 1'b0);
        check("R11 brk low", brk_req, 1'b0);
        @(negedge clk);
        bus_addr = b_addr; bus_size = 2'b00; bus_fetch = 1'b0; bus_valid = 1'b1; b_clr = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; b_clr = 1'b0;
        check("R10 hit wins over clear", b_hit, 1'b1);
        clear_both();
        a_en = 1'b1; a_addr = 32'h0000_4000;
        bus_cycle(32'h0000_4000, 32'h0, 2'b10, 1'b0, 1'b0);
        check("R11 A only a_hit", a_hit, 1'b1);
        check("R11 A only brk", brk_req, 1'b1);
        bus_cycle(b_addr, 32'h0, 2'b00, 1'b0, 1'b0);
        check("R11 both b_hit", b_hit, 1'b1);
        a_clr = 1'b1;
        @(negedge clk);
        a_clr = 1'b0;
        check("R10 clear A only", a_hit, 1'b0);
        check("R11 brk from B only", brk_req, 1'b1);
        clear_both();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule